// File: doc/BRIEF.md
# SMBus Register Target

This block is the target side of a two-wire SMBus/I2C link with a fixed 7-bit device address. It samples the bus clock and data lines through synchronizers and runs a bit-level protocol engine from the system clock. It pulls the data line low through an open-drain enable and never drives it high. Behind the engine is a small file of 16-bit registers. A command pointer picks one of them, and that pointer is kept from one transaction to the next.

A host on the bus can set the pointer with a single byte (Send Byte). It can set the pointer and then write one or two bytes (Write Byte, Write Word). It can set the pointer and then turn the bus around with a repeated start to read one or two bytes (Read Byte, Read Word, Process Call). It can also read with no command byte at all (Receive Byte), which returns the register chosen by the last command. A separate parallel port lets local logic preload and observe every register. Clock stretching, packet error checking, block transfers and general call are not handled.

Top module: `smbreg_target`

## Requirements
- R1: The target acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper seven bits equal DEV_ADDR, with bit 0 as direction (1 = read). For any other address it leaves SDA released for the rest of that transaction. It does not acknowledge the bytes that follow, and it writes no register.
- R2: In a write transaction the first byte after the address is taken as the command pointer, and it is acknowledged. The register it selects is the pointer value modulo NREG (its low log2(NREG) bits). A Send Byte consists of this byte and nothing more.
- R3: The second byte of a write transaction replaces the low byte of the selected register, and the third byte replaces the high byte. Any later bytes are acknowledged and ignored.
- R4: In a read transaction the target shifts out the low byte of the selected register first, MSB first, then the high byte. Further acknowledged reads alternate low, high, low.
- R5: A read transaction with no command byte (Receive Byte) returns the register selected by the pointer of an earlier transaction.
- R6: A repeated start after a command byte keeps the pointer and begins a new address phase. A read address then gives Read Byte, Read Word or Process Call framing, and the read returns values written earlier in the same transaction.
- R7: After the host NACKs a read byte, the target keeps SDA released until the next start or stop.
- R8: The parallel port writes hp_wdata_i into register hp_idx_i on a clock where hp_we_i is high. hp_rdata_o always shows register hp_idx_i.
- R9: The target changes SDA from released to driven only while SCL is low.
- R10: After reset all registers and the pointer are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| hp_we_i | input | 1 | Parallel port write strobe |
| hp_idx_i | input | IDXW | Parallel port register index |
| hp_wdata_i | input | 16 | Parallel port write data |
| hp_rdata_o | output | 16 | Parallel port read data of register hp_idx_i |

## Verification
The bench builds the target with DEV_ADDR = 0x3C and NREG = 4. With only four registers, a command value of 0x05 folds onto register 1, so the modulo selection of R2 can be seen through the parallel port. An address of 0x11 shows that a foreign transaction has no effect. The bench also reads three bytes in a row to cover the low/high alternation. It combines a write phase with a read phase around a repeated start, so the pointer is checked both within a transaction and across transactions.

// File: rtl/smbt_pkg.sv
// Shared types for the SMBus register target.
// Assumes: nothing beyond IEEE 1800-2017.
package smbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // no transaction, waiting for start
        ST_RX    = 3'd1,   // shifting in a byte from the host
        ST_RXACK = 3'd2,   // driving the acknowledge of a received byte
        ST_TX    = 3'd3,   // shifting out a byte to the host
        ST_TXACK = 3'd4,   // sampling the host acknowledge
        ST_WAIT  = 3'd5    // off the bus until start or stop
    } smbt_state_e;
endpackage

// File: rtl/smbt_sync.sv
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes: the host keeps SDA stable while SCL is high, except when it
// signals start or stop; the lines idle high.
module smbt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;

    // Synchronizer chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    // Event decode: SDA edges while SCL stays high frame the transaction.
    always_comb begin
        scl_o      = scl_pipe[STAGES-1];
        sda_o      = sda_pipe[STAGES-1];
        scl_rise_o = scl_o && !scl_prev;
        scl_fall_o = !scl_o && scl_prev;
        start_o    = scl_o && scl_prev && sda_prev && !sda_o;
        stop_o     = scl_o && scl_prev && !sda_prev && sda_o;
    end
endmodule

// File: rtl/smbt_regfile.sv
// Register file of NREG 16-bit registers with a parallel port and a bus port.
// Assumes: the parallel port wins if both ports write one register at once.
module smbt_regfile #(
    parameter int NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hp_we,
    input  logic [IDXW-1:0] hp_idx,
    input  logic [15:0]     hp_wdata,
    output logic [15:0]     hp_rdata,
    input  logic            bus_we_lo,
    input  logic            bus_we_hi,
    input  logic [IDXW-1:0] bus_idx,
    input  logic [7:0]      bus_byte,
    output logic [15:0]     bus_rdata
);
    logic [15:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One register: parallel write, else byte-lane write from the bus.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (hp_we && hp_idx == IDXW'(g)) begin
                regs[g] <= hp_wdata;
            end else if (bus_idx == IDXW'(g)) begin
                if (bus_we_lo) regs[g][7:0]  <= bus_byte;
                if (bus_we_hi) regs[g][15:8] <= bus_byte;
            end
        end
    end

    // Asynchronous read ports.
    always_comb begin
        hp_rdata  = regs[hp_idx];
        bus_rdata = regs[bus_idx];
    end
endmodule

// File: rtl/smbt_proto.sv
// Bit-level protocol engine: address match, command pointer, byte lanes,
// read shifting and acknowledge handling.
// Assumes: synchronized inputs from smbt_sync; no clock stretching.
module smbt_proto
    import smbt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NREG     = 8,
    localparam int        IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start,
    input  logic            stop,
    input  logic [15:0]     rdata,
    output logic [IDXW-1:0] ptr,
    output logic            we_lo,
    output logic            we_hi,
    output logic [7:0]      wbyte,
    output logic            sda_oe,
    output smbt_state_e     state
);
    smbt_state_e     st_q;
    logic [3:0]      bitcnt;
    logic [7:0]      sh, tx_sh;
    logic            is_addr, rd_dir, lane_hi, oe_q;
    logic [1:0]      wcnt;
    logic [IDXW-1:0] ptr_q;
    logic            byte_done;
    logic [7:0]      next_tx;

    // Decode of a completed write byte and of the next read byte.
    always_comb begin
        byte_done = (st_q == ST_RX) && scl_fall && (bitcnt == 4'd8) && !is_addr;
        we_lo     = byte_done && (wcnt == 2'd1);
        we_hi     = byte_done && (wcnt == 2'd2);
        wbyte     = sh;
        next_tx   = lane_hi ? rdata[15:8] : rdata[7:0];
        ptr       = ptr_q;
        sda_oe    = oe_q;
        state     = st_q;
    end

    // Main sequencer; start and stop override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            tx_sh   <= '0;
            is_addr <= 1'b0;
            rd_dir  <= 1'b0;
            lane_hi <= 1'b0;
            oe_q    <= 1'b0;
            wcnt    <= '0;
            ptr_q   <= '0;
        end else if (stop) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
        end else if (start) begin
            st_q    <= ST_RX;
            bitcnt  <= '0;
            is_addr <= 1'b1;
            wcnt    <= '0;
            oe_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        sh     <= {sh[6:0], sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall && bitcnt == 4'd8) begin
                        if (is_addr) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                oe_q    <= 1'b1;
                                rd_dir  <= sh[0];
                                lane_hi <= 1'b0;
                                st_q    <= ST_RXACK;
                            end else begin
                                st_q <= ST_WAIT;
                            end
                            is_addr <= 1'b0;
                        end else begin
                            oe_q <= 1'b1;
                            st_q <= ST_RXACK;
                            if (wcnt == 2'd0) ptr_q <= sh[IDXW-1:0];
                            if (wcnt != 2'd3) wcnt <= wcnt + 2'd1;
                        end
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_dir) begin
                            tx_sh <= next_tx;
                            oe_q  <= ~next_tx[7];
                            st_q  <= ST_TX;
                        end else begin
                            oe_q <= 1'b0;
                            st_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            oe_q    <= 1'b0;
                            lane_hi <= ~lane_hi;
                            st_q    <= ST_TXACK;
                        end else if (bitcnt != 4'd0) begin
                            tx_sh <= {tx_sh[6:0], 1'b0};
                            oe_q  <= ~tx_sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise && sda) begin
                        st_q <= ST_WAIT;
                    end else if (scl_fall) begin
                        tx_sh  <= next_tx;
                        oe_q   <= ~next_tx[7];
                        bitcnt <= '0;
                        st_q   <= ST_TX;
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smbreg_target.sv
// Top of the SMBus register target: synchronizer, protocol engine and
// register file.
// Assumes: NREG is a power of two, at least 2; SDA is open drain outside.
module smbreg_target
    import smbt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         NREG        = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDXW        = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic            hp_we_i,
    input  logic [IDXW-1:0] hp_idx_i,
    input  logic [15:0]     hp_wdata_i,
    output logic [15:0]     hp_rdata_o
);
    logic            scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [IDXW-1:0] ptr;
    logic            we_lo, we_hi;
    logic [7:0]      wbyte;
    logic [15:0]     bus_rdata;
    smbt_state_e     proto_state;
    logic            scl_unused;

    // The level of SCL itself is only needed through its edges.
    always_comb scl_unused = scl_s;

    smbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(bus_start), .stop_o(bus_stop)
    );

    smbt_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start(bus_start), .stop(bus_stop),
        .rdata(bus_rdata), .ptr(ptr), .we_lo(we_lo), .we_hi(we_hi),
        .wbyte(wbyte), .sda_oe(sda_oe_o), .state(proto_state)
    );

    smbt_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .hp_we(hp_we_i), .hp_idx(hp_idx_i),
        .hp_wdata(hp_wdata_i), .hp_rdata(hp_rdata_o),
        .bus_we_lo(we_lo), .bus_we_hi(we_hi), .bus_idx(ptr),
        .bus_byte(wbyte), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/smbt_checker.sv
// Temporal checks on the SMBus register target, bound to its top.
// Assumes: the bus host obeys the framing rules of the brief.
module smbt_checker
    import smbt_pkg::*;
#(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_oe_o,
    input smbt_state_e     state,
    input logic            hp_we_i,
    input logic [IDXW-1:0] hp_idx_i,
    input logic [15:0]     hp_wdata_i,
    input logic [15:0]     hp_rdata_o
);
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && !$past(sda_oe_o)) |-> !scl_i);

    assert_wait_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe_o);

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    assert_port_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hp_we_i |=> (hp_idx_i != $past(hp_idx_i)) || (hp_rdata_o == $past(hp_wdata_i)));

    assert_no_ack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WAIT && state == ST_WAIT) |-> $stable(sda_oe_o));
endmodule

bind smbreg_target smbt_checker #(.IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .state(proto_state), .hp_we_i(hp_we_i), .hp_idx_i(hp_idx_i),
    .hp_wdata_i(hp_wdata_i), .hp_rdata_o(hp_rdata_o)
);

// File: tb/smbreg_target_bench.sv
// Scoreboard bench: a bit-banged bus host drives transactions, read tasks
// push expected bytes, a monitor pops and compares the observed bytes.
module smbreg_target_bench;
    localparam logic [6:0] ADDR = 7'h3C;
    localparam int         NR   = 4;
    localparam int         Q    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic        hp_we = 1'b0;
    logic [1:0]  hp_idx = '0;
    logic [15:0] hp_wdata = '0;
    logic [15:0] hp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int r9_viol = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } item_t;
    item_t      exp_q[$];
    logic [7:0] obs_q[$];

    always #5 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    smbreg_target #(.DEV_ADDR(ADDR), .NREG(NR)) u_smbreg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .hp_we_i(hp_we), .hp_idx_i(hp_idx),
        .hp_wdata_i(hp_wdata), .hp_rdata_o(hp_rdata)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Watch for the target pulling SDA low while SCL is high (R9).
    always @(negedge clk) begin
        if (rst_n && sda_oe && !$past(sda_oe) && scl) r9_viol++;
    end

    // Monitor: compare every observed read byte with the next expected one.
    initial begin
        forever begin
            wait (obs_q.size() != 0);
            begin
                logic [7:0] o;
                item_t e;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    check("scoreboard", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, int'(o), int'(e.val));
                end
            end
        end
    end

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_low = ~b; tick(Q);
        scl = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, ack);
    endtask

    task automatic rd_byte(input logic [7:0] exp, input string req,
                           input logic nack);
        logic [7:0] d;
        logic s;
        item_t it;
        it.val = exp; it.req = req;
        exp_q.push_back(it);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
        obs_q.push_back(d);
    endtask

    task automatic host_wr(input logic [1:0] idx, input logic [15:0] v);
        hp_idx = idx; hp_wdata = v; hp_we = 1'b1; tick(1);
        hp_we = 1'b0; tick(1);
    endtask

    task automatic host_chk(input logic [1:0] idx, input logic [15:0] v,
                            input string req);
        hp_idx = idx; tick(1);
        check(req, int'(hp_rdata), int'(v));
    endtask

    initial begin
        #2ms;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic a;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R10: reset state.
        check("R10 sda released", int'(sda_oe), 0);
        for (int i = 0; i < NR; i++) host_chk(2'(i), 16'h0000, "R10 register zero");

        // R8: parallel preload and read back.
        host_wr(2'd2, 16'hBEEF);
        host_chk(2'd2, 16'hBEEF, "R8 parallel write");

        // R3/R1: Write Word to register 1.
        bus_start();
        wr_byte({ADDR, 1'b0}, a); check("R1 own address ack", int'(a), 0);
        wr_byte(8'h01, a);        check("R2 command ack", int'(a), 0);
        wr_byte(8'h34, a);        check("R3 low byte ack", int'(a), 0);
        wr_byte(8'h12, a);        check("R3 high byte ack", int'(a), 0);
        bus_stop();
        host_chk(2'd1, 16'h1234, "R3 word write");

        // R6/R4: Read Word through repeated start.
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h02, a);
        bus_start();
        wr_byte({ADDR, 1'b1}, a); check("R6 read address ack", int'(a), 0);
        rd_byte(8'hEF, "R4 low byte first", 1'b0);
        rd_byte(8'hBE, "R4 high byte second", 1'b1);
        bus_stop();

        // R5: Receive Byte uses the pointer of the last transaction.
        bus_start();
        wr_byte({ADDR, 1'b1}, a);
        rd_byte(8'hEF, "R5 receive byte keeps pointer", 1'b1);
        bus_stop();

        // R2: Send Byte 0x05 folds onto register 1 with NREG = 4.
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h05, a); check("R2 send byte ack", int'(a), 0);
        bus_stop();
        bus_start();
        wr_byte({ADDR, 1'b1}, a);
        rd_byte(8'h34, "R2 pointer modulo NREG", 1'b1);
        bus_stop();

        // R1: foreign address is ignored.
        bus_start();
        wr_byte({7'h11, 1'b0}, a); check("R1 foreign address nack", int'(a), 1);
        wr_byte(8'h01, a);         check("R1 foreign command nack", int'(a), 1);
        wr_byte(8'h55, a);         check("R1 foreign data nack", int'(a), 1);
        bus_stop();
        host_chk(2'd1, 16'h1234, "R1 foreign write has no effect");

        // R3: bytes beyond the high byte are acked and ignored.
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h03, a);
        wr_byte(8'hAA, a);
        wr_byte(8'hBB, a);
        wr_byte(8'hCC, a); check("R3 extra byte ack", int'(a), 0);
        bus_stop();
        host_chk(2'd3, 16'hBBAA, "R3 extra byte ignored");

        // R6: Process Call returns the word just written.
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h00, a);
        wr_byte(8'h11, a);
        wr_byte(8'h22, a);
        bus_start();
        wr_byte({ADDR, 1'b1}, a);
        rd_byte(8'h11, "R6 process call low", 1'b0);
        rd_byte(8'h22, "R6 process call high", 1'b1);
        bus_stop();

        // R4/R7: three reads alternate lanes; after the NACK SDA stays free.
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h03, a);
        bus_start();
        wr_byte({ADDR, 1'b1}, a);
        rd_byte(8'hAA, "R4 alternate low", 1'b0);
        rd_byte(8'hBB, "R4 alternate high", 1'b0);
        rd_byte(8'hAA, "R4 alternate low again", 1'b1);
        begin
            logic s;
            int driven;
            driven = 0;
            for (int i = 0; i < 4; i++) begin
                clk_bit(1'b1, s);
                if (!s) driven++;
            end
            check("R7 released after nack", driven, 0);
        end
        bus_stop();

        check("R9 drive only with scl low", r9_viol, 0);
        tick(20);
        check("scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule